// File: doc/BRIEF.md
# Data Bus Tenure Termination Controller

This block is the master-side tracker for one data bus tenure on a split-transaction processor bus. A request with a beat count and a direction opens the tenure and raises the bus-busy output. From then on the block watches three termination inputs: the per-beat acknowledge, the data retry and the transfer error. It counts beats until the whole burst has been confirmed, and it tells the core side which beats are final.

A beat is not final when its acknowledge arrives. In the normal operating mode, the beat is held for one cycle, and a retry in that cycle throws it away so that it must be sent again. A transfer error ends the tenure at once and raises a machine-check request. Beats that were already confirmed stay confirmed. The level of the retry input on the last clock of reset selects a fast streaming mode. In that mode there is no retry window: every acknowledged beat is final at once.

Top module: `dbt_ctrl`

## Requirements
- R1: While reset is held, all four outputs are low. The retry input level sampled at the last clock edge with rst_n low selects the mode: 1 gives fast streaming, 0 gives normal.
- R2: A start request while idle, with a beat count from 1 to MAX_BEATS, raises dbb_o from the next cycle. Other inputs have no effect on the outputs in these cases: a start while a tenure is open, a start with a count of 0, and an acknowledge or retry while idle.
- R3: In normal mode, an acknowledge in cycle t is confirmed with commit_o high in cycle t+2 only if retry is low in t+1. If retry is high in t+1, the beat is cancelled and does not count toward the burst.
- R4: In normal mode, while retry is held for several cycles, each acknowledge is cancelled by the retry in the cycle after it. The acknowledge given in the cycle just before retry negates is the one that is confirmed.
- R5: In normal mode, dbb_o goes low in the cycle after the acknowledge that covers the last outstanding beat. After that, the tenure stays open with dbb_o low: a retry still cancels that beat, and further acknowledges are accepted until the last beat is confirmed.
- R6: done_o is a one-cycle pulse. It appears in the same cycle as the commit_o of the final beat, and dbb_o is low in that cycle.
- R7: A transfer error seen in cycle t while dbb_o is high, or during the open tail of R5, ends the tenure. In cycle t+1, dbb_o is low, mchk_o and done_o pulse for one cycle, and commit_o stays low. Acknowledge and retry in cycle t are ignored, a beat awaiting its retry window is dropped, and beats already confirmed stand.
- R8: A transfer error is acted on only in the first cycle of its assertion. If that first cycle lies outside a tenure, the whole assertion is ignored.
- R9: In fast mode, retry is ignored and an acknowledge in cycle t gives commit_o in t+1. After the last beat, dbb_o and done_o change in that same cycle t+1.
- R10: In fast mode, a transfer error in the cycle right after an acknowledge is ignored during a read. During a write it is honoured as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Open a data tenure |
| beats_i | input | BW | Number of beats in the tenure (1..MAX_BEATS) |
| write_i | input | 1 | 1 for a write tenure, 0 for a read |
| ta_i | input | 1 | Beat acknowledge |
| drtry_i | input | 1 | Data retry; also the mode strap during reset |
| tea_i | input | 1 | Transfer error |
| dbb_o | output | 1 | Data bus busy |
| commit_o | output | 1 | One beat confirmed to the core |
| mchk_o | output | 1 | Machine-check request pulse |
| done_o | output | 1 | Tenure finished pulse |

## Verification
The hardest state to reach is the open tail after dbb_o has dropped. There, one outstanding beat is still waiting for its retry window, and a retry, a fresh acknowledge or an error can still change the result. The stimulus gets there with a one-beat burst, so the first acknowledge already lowers the bus-busy output. It then holds retry while repeating the acknowledge for several cycles before releasing it. Separate sequences start an error inside the tenure, start an error in idle and hold it into the tenure, and give an error right after a fast-mode acknowledge, once for a read and once for a write. A behavioural model compares all four outputs on every clock.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
    typedef enum logic [1:0] {
        T_IDLE = 2'd0,
        T_BUSY = 2'd1,
        T_TAIL = 2'd2
    } tstate_e;
endpackage

// File: rtl/dbt_mode_latch.sv
module dbt_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_i,
    output logic fast_o
);
    logic fast_d, fast_q;

    // The strap is followed while reset is held and frozen when reset ends.
    always_comb fast_d = rst_n ? fast_q : strap_i;

    always_ff @(posedge clk) fast_q <= fast_d;

    assign fast_o = fast_q;

    a_r1_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(fast_o));
endmodule

// File: rtl/dbt_err_filter.sv
module dbt_err_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic tea_i,
    input  logic ta_i,
    input  logic in_tenure_i,
    input  logic fast_i,
    input  logic write_i,
    output logic tea_rec_o
);
    typedef struct packed {
        logic tea_prev;
        logic ta_prev;
    } flt_t;

    flt_t f_d, f_q;

    always_comb begin
        f_d.tea_prev = tea_i;
        f_d.ta_prev  = ta_i;
        // Only the first cycle of an error counts. A fast-mode read also
        // drops an error that comes right after an acknowledge.
        tea_rec_o = tea_i && !f_q.tea_prev && in_tenure_i
                    && !(fast_i && !write_i && f_q.ta_prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    a_r8_first_cycle_only: assert property (@(posedge clk) disable iff (!rst_n)
        tea_rec_o |=> !tea_rec_o);
    a_r10_fast_read_blind: assert property (@(posedge clk) disable iff (!rst_n)
        (ta_i && fast_i && !write_i) |=> !tea_rec_o);
endmodule

// File: rtl/dbt_ctrl.sv
module dbt_ctrl #(
    parameter int MAX_BEATS = 8,
    parameter int BW        = $clog2(MAX_BEATS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [BW-1:0] beats_i,
    input  logic          write_i,
    input  logic          ta_i,
    input  logic          drtry_i,
    input  logic          tea_i,
    output logic          dbb_o,
    output logic          commit_o,
    output logic          mchk_o,
    output logic          done_o
);
    import dbt_pkg::*;

    localparam logic [BW-1:0] ONE = BW'(1);

    typedef struct packed {
        tstate_e       st;
        logic [BW-1:0] rem;
        logic          pend;
        logic          wr;
        logic          commit;
        logic          mchk;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;
    logic  fast, tea_rec, in_ten;
    logic  commit_now, ta_ok;
    logic [BW-1:0] outstanding;

    assign in_ten = (r_q.st != T_IDLE);

    dbt_mode_latch u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .strap_i(drtry_i),
        .fast_o (fast)
    );

    dbt_err_filter u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .tea_i      (tea_i),
        .ta_i       (ta_i),
        .in_tenure_i(in_ten),
        .fast_i     (fast),
        .write_i    (r_q.wr),
        .tea_rec_o  (tea_rec)
    );

    always_comb begin
        r_d         = r_q;
        r_d.commit  = 1'b0;
        r_d.mchk    = 1'b0;
        r_d.done    = 1'b0;
        commit_now  = 1'b0;
        ta_ok       = 1'b0;
        outstanding = r_q.rem;
        if (r_q.st == T_IDLE) begin
            r_d.pend = 1'b0;
            if (start_i && beats_i != '0) begin
                r_d.st  = T_BUSY;
                r_d.rem = beats_i;
                r_d.wr  = write_i;
            end
        end else if (tea_rec) begin
            r_d.st   = T_IDLE;
            r_d.rem  = '0;
            r_d.pend = 1'b0;
            r_d.mchk = 1'b1;
            r_d.done = 1'b1;
        end else begin
            if (fast) begin
                commit_now  = ta_i && (r_q.rem != '0);
                outstanding = r_q.rem - (commit_now ? ONE : '0);
                r_d.pend    = 1'b0;
                if (outstanding == '0) r_d.st = T_IDLE;
            end else begin
                // The held beat becomes final unless retry hits its window.
                commit_now  = r_q.pend && !drtry_i;
                outstanding = r_q.rem - (commit_now ? ONE : '0);
                ta_ok       = ta_i && (outstanding != '0);
                r_d.pend    = ta_ok;
                if (outstanding == '0)              r_d.st = T_IDLE;
                else if (ta_ok && outstanding == ONE) r_d.st = T_TAIL;
            end
            r_d.rem    = outstanding;
            r_d.commit = commit_now;
            r_d.done   = commit_now && (outstanding == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= T_IDLE;
            r_q.rem    <= '0;
            r_q.pend   <= 1'b0;
            r_q.wr     <= 1'b0;
            r_q.commit <= 1'b0;
            r_q.mchk   <= 1'b0;
            r_q.done   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dbb_o    = (r_q.st == T_BUSY);
    assign commit_o = r_q.commit;
    assign mchk_o   = r_q.mchk;
    assign done_o   = r_q.done;

    a_r2_open_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ten && start_i && beats_i != '0) |=> dbb_o);
    a_r3_retry_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (!fast && in_ten && r_q.pend && drtry_i) |=> !commit_o);
    a_r6_done_bus_free: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !dbb_o);
    a_r7_err_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        tea_rec |=> (!dbb_o && mchk_o && done_o && !commit_o));
    a_r7_mchk_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mchk_o |=> !mchk_o);
    a_r9_fast_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (fast && dbb_o && ta_i && !tea_rec) |=> commit_o);
endmodule

// File: tb/dbt_ctrl_tb.sv
`timescale 1ns/1ps
module dbt_ctrl_tb;
    localparam int MAXB = 8;
    localparam int BW   = $clog2(MAXB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, write_i = 1'b0, ta_i = 1'b0, drtry_i = 1'b0, tea_i = 1'b0;
    logic [BW-1:0] beats_i = '0;
    logic dbb_o, commit_o, mchk_o, done_o;

    always #2 clk = ~clk;

    dbt_ctrl #(.MAX_BEATS(MAXB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .beats_i(beats_i),
        .write_i(write_i), .ta_i(ta_i), .drtry_i(drtry_i), .tea_i(tea_i),
        .dbb_o(dbb_o), .commit_o(commit_o), .mchk_o(mchk_o), .done_o(done_o)
    );

    int checks = 0, errors = 0;
    string cur_req = "R1";
    bit summary_done = 0;
    int n_commit = 0, n_done = 0, n_mchk = 0;

    // Behavioural reference: phase 0 idle, 1 bus held, 2 bus released with a beat still open
    bit m_valid = 0, m_fast = 0, m_wr = 0, m_prov = 0, m_tlast = 0, m_alast = 0;
    int m_phase = 0, m_left = 0;
    bit e_dbb = 0, e_commit = 0, e_mchk = 0, e_done = 0;

    always @(posedge clk) begin
        bit err_hit;
        if (!rst_n) begin
            m_fast = drtry_i; m_phase = 0; m_left = 0; m_prov = 0; m_wr = 0;
            m_tlast = 0; m_alast = 0;
            e_commit = 0; e_mchk = 0; e_done = 0;
        end else begin
            err_hit = tea_i && !m_tlast && m_phase != 0 && !(m_fast && !m_wr && m_alast);
            e_commit = 0; e_mchk = 0; e_done = 0;
            if (m_phase == 0) begin
                m_prov = 0;
                if (start_i && beats_i != 0) begin
                    m_phase = 1; m_left = int'(beats_i); m_wr = write_i;
                end
            end else if (err_hit) begin
                m_phase = 0; m_left = 0; m_prov = 0; e_mchk = 1; e_done = 1;
            end else if (m_fast) begin
                if (ta_i && m_left > 0) begin
                    m_left--; e_commit = 1;
                    if (m_left == 0) begin m_phase = 0; e_done = 1; end
                end
            end else begin
                if (m_prov && !drtry_i) begin m_left--; e_commit = 1; end
                m_prov = ta_i && m_left > 0;
                if (m_left == 0) begin m_phase = 0; e_done = e_commit; end
                else if (m_prov && m_left == 1) m_phase = 2;
            end
            m_tlast = tea_i; m_alast = ta_i;
        end
        e_dbb = (m_phase == 1);
        m_valid = 1;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (m_valid && !summary_done) begin
            check(cur_req, "dbb_o", dbb_o, e_dbb);
            check(cur_req, "commit_o", commit_o, e_commit);
            check(cur_req, "mchk_o", mchk_o, e_mchk);
            check(cur_req, "done_o", done_o, e_done);
            n_commit += commit_o; n_done += done_o; n_mchk += mchk_o;
        end
    end

    task automatic cyc(input bit st, input int nb, input bit w, input bit ta, input bit dr, input bit te);
        @(negedge clk);
        start_i = st; beats_i = BW'(nb); write_i = w; ta_i = ta; drtry_i = dr; tea_i = te;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic counters_clear();
        @(negedge clk); #1;
        n_commit = 0; n_done = 0; n_mchk = 0;
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 0; drtry_i = strap; start_i = 0; ta_i = 0; tea_i = 0;
        repeat (3) @(negedge clk);
        check("R1", "dbb_o in reset", dbb_o, 0);
        check("R1", "commit_o in reset", commit_o, 0);
        check("R1", "mchk_o in reset", mchk_o, 0);
        check("R1", "done_o in reset", done_o, 0);
        rst_n = 1; drtry_i = 0;
    endtask

    initial begin
        do_reset(0);
        quiet(2);

        // R2 and R5: four-beat write, plus a start while busy and a start with a count of 0
        cur_req = "R2"; counters_clear();
        cyc(1, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R2", "dbb_o after zero-count start", dbb_o, 0);
        cyc(1, 4, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(1, 7, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        quiet(4);
        cyc(0, 0, 0, 1, 0, 0);
        quiet(3);
        check("R2", "beats confirmed, start while busy ignored", n_commit, 4);
        check("R6", "done pulses", n_done, 1);

        // R3: single retry cancels one beat
        cur_req = "R3"; counters_clear();
        cyc(1, 2, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 0, 0);
        quiet(4);
        check("R3", "beats confirmed after retry", n_commit, 2);

        // R4 and R5: one beat, retry held in the open tail
        cur_req = "R4"; counters_clear();
        cyc(1, 1, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        #1 check("R5", "dbb_o low in tail", dbb_o, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        quiet(4);
        check("R4", "one beat confirmed after held retry", n_commit, 1);
        check("R6", "single done", n_done, 1);

        // R7: error mid-tenure, with ack and retry in the same cycle
        cur_req = "R7"; counters_clear();
        cyc(1, 4, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 1);
        quiet(4);
        check("R7", "confirmed before error", n_commit, 1);
        check("R7", "machine checks", n_mchk, 1);
        check("R7", "done on abort", n_done, 1);

        // R7 in the tail: error while the bus is already released
        counters_clear();
        cyc(1, 1, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0, 1);
        quiet(4);
        check("R7", "tail abort mchk", n_mchk, 1);
        check("R7", "tail abort commits", n_commit, 0);

        // R8: error raised in idle and held into the tenure
        cur_req = "R8"; counters_clear();
        cyc(0, 0, 0, 0, 0, 1);
        cyc(1, 2, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 1, 0, 0);
        quiet(4);
        check("R8", "no machine check", n_mchk, 0);
        check("R8", "beats confirmed", n_commit, 2);

        // Fast streaming mode
        do_reset(1);
        quiet(2);
        cur_req = "R9"; counters_clear();
        cyc(1, 3, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        cyc(0, 0, 0, 1, 1, 0);
        quiet(3);
        check("R9", "retry ignored, beats", n_commit, 3);
        check("R9", "done", n_done, 1);

        cur_req = "R10"; counters_clear();
        cyc(1, 3, 0, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        quiet(3);
        check("R10", "read error after ack ignored", n_mchk, 0);
        check("R10", "read beats", n_commit, 3);

        counters_clear();
        cyc(1, 3, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 1);
        quiet(4);
        check("R10", "write error honoured", n_mchk, 1);
        check("R10", "write beats before error", n_commit, 1);

        if (!summary_done) begin
            summary_done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!summary_done) begin
            summary_done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule